// File: doc/BRIEF.md
# Reconfiguration Write Sequencer

This block performs one register-level settings update on a transceiver reconfiguration controller. It is the memory-mapped bus master for that update. A requester hands it a logical channel number, a feature offset and a data word over a valid/ready request port. The sequencer then runs a fixed chain of bus accesses:

1. It reads the controller's control/status word until the busy flag is clear.
2. It writes the channel register, the offset register and the data register, in that order.
3. It writes the launch command into the control/status word.
4. It reads the control/status word again until busy clears.

When the chain ends, it pulses `done`. If a busy-wait runs too long, it pulses `done` together with `timeout`.

The request port can hold the requester off. `req_ready` is high only while the sequencer is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. From that edge until `done` pulses, `req_ready` stays low, so a requester simply keeps `req_valid` high until it is taken. The channel, offset and data are captured on the accepting edge and may change afterwards. The bus side follows a wait-request protocol: an access stays presented until the slave drops `bus_waitrequest`, and read data is taken in that same cycle.

Top module: `reconfig_write_seq`

## Requirements
- R1: After reset, and while reset is held, `req_ready` is 1, and `bus_read`, `bus_write`, `done` and `timeout` are 0.
- R2: A request is accepted only when idle, on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the following cycle until the cycle `done` is high. The written channel, offset and data are the values present at the accepting edge.
- R3: After acceptance, the block reads control/status address 2 repeatedly and issues no write until a read returns bit 8 (busy) equal to 0. All other read-data bits are ignored.
- R4: After the first poll ends, exactly four writes follow, in this order: channel to address 0, offset to address 3, data to address 4, then value 1 (bit 0, the launch bit) to address 2. Channel and offset are zero-extended.
- R5: After the launch write, the block reads address 2 repeatedly until bit 8 reads 0.
- R6: While an access is presented and `bus_waitrequest` is 1, the address, read, write and write data are held unchanged. An access completes in the first cycle with `bus_waitrequest` at 0.
- R7: `done` is high for exactly one cycle. It rises in the cycle after the final access completes, which is N*(W+1) cycles after the accepting edge, for N accesses each stalled W cycles.
- R8: In either polling phase, the busy-1 reads are counted. If that count exceeds `poll_limit`, then on that read `done` and `timeout` pulse together, the block returns to idle and issues no further access. A timeout in the first phase means no write is issued.
- R9: `bus_read` and `bus_write` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_channel | input | CH_W | Logical channel to update |
| req_offset | input | OFS_W | Feature offset address |
| req_data | input | DATA_W | Value for the data register |
| poll_limit | input | PL_W | Busy-1 reads tolerated per polling phase |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | High with `done` when a poll phase exceeded the limit |
| bus_address | output | ADDR_W | Word address of the current access |
| bus_read | output | 1 | Read access |
| bus_write | output | 1 | Write access |
| bus_writedata | output | DATA_W | Write data |
| bus_readdata | input | DATA_W | Read data, valid when a read completes |
| bus_waitrequest | input | 1 | Slave stall |

## Verification
Every access costs W+1 cycles against a slave that stalls W cycles. `done` is therefore due exactly N*(W+1) cycles after the accepting edge. N is derived per vector from the busy lengths and the limit: the pre-poll reads, plus four writes when the first phase does not time out, plus the post-poll reads.

The bench timestamps the accepting edge and reads `done` and `timeout` on the falling edge of that cycle. It checks `req_ready` on the falling edge straight after acceptance, and the one-cycle width of the pulse on the falling edge after that. The order, addresses and data of the writes and the read counts per phase come from a bench-side slave log. That log is compared once `done` has been seen.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PRE    = 3'd1,
    PH_CHAN   = 3'd2,
    PH_OFS    = 3'd3,
    PH_DATA   = 3'd4,
    PH_LAUNCH = 3'd5,
    PH_POST   = 3'd6
  } phase_t;

  function automatic logic is_poll(phase_t p);
    return (p == PH_PRE) || (p == PH_POST);
  endfunction

  function automatic logic is_load(phase_t p);
    return (p == PH_CHAN) || (p == PH_OFS) || (p == PH_DATA) || (p == PH_LAUNCH);
  endfunction

endpackage

// File: rtl/rcw_req_latch.sv
module rcw_req_latch #(
  parameter int CH_W   = 10,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic [DATA_W-1:0] in_data,
  output logic [CH_W-1:0]   ch_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [DATA_W-1:0] data_q
);

  // Request fields are captured only on the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      ofs_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      ch_q   <= in_ch;
      ofs_q  <= in_ofs;
      data_q <= in_data;
    end
  end

endmodule

// File: rtl/rcw_bus_drive.sv
module rcw_bus_drive
  import rcw_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int CH_W      = 10,
  parameter int OFS_W     = 16,
  parameter int CH_ADDR   = 0,
  parameter int CSR_ADDR  = 2,
  parameter int OFS_ADDR  = 3,
  parameter int DATA_ADDR = 4,
  parameter int WR_BIT    = 0
) (
  input  phase_t            phase,
  input  logic [CH_W-1:0]   ch,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] address,
  output logic              rd,
  output logic              wr,
  output logic [DATA_W-1:0] wdata
);

  localparam logic [ADDR_W-1:0] A_CH   = ADDR_W'(CH_ADDR);
  localparam logic [ADDR_W-1:0] A_CSR  = ADDR_W'(CSR_ADDR);
  localparam logic [ADDR_W-1:0] A_OFS  = ADDR_W'(OFS_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [DATA_W-1:0] LAUNCH_WORD = DATA_W'(1) << WR_BIT;

  // The bus lines are a pure function of the phase, so they cannot move
  // while the phase waits on a stalled access.
  always_comb begin
    address = '0;
    wdata   = '0;
    rd      = is_poll(phase);
    wr      = is_load(phase);
    unique case (phase)
      PH_PRE, PH_POST: address = A_CSR;
      PH_CHAN: begin
        address = A_CH;
        wdata   = DATA_W'(ch);
      end
      PH_OFS: begin
        address = A_OFS;
        wdata   = DATA_W'(ofs);
      end
      PH_DATA: begin
        address = A_DATA;
        wdata   = data;
      end
      PH_LAUNCH: begin
        address = A_CSR;
        wdata   = LAUNCH_WORD;
      end
      default: begin
        address = '0;
        wdata   = '0;
      end
    endcase
  end

endmodule

// File: rtl/rcw_poll_guard.sv
module rcw_poll_guard #(
  parameter int PL_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            busy_hit,
  input  logic [PL_W-1:0] limit,
  output logic            over
);

  logic [PL_W-1:0] count_q;

  // count_q holds the busy-1 reads seen so far in this phase. The current hit
  // pushes the total past the limit when count_q has already reached it.
  assign over = busy_hit && (count_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (busy_hit && !over) begin
      count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/reconfig_write_seq.sv
module reconfig_write_seq
  import rcw_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int CH_W      = 10,
  parameter int OFS_W     = 16,
  parameter int PL_W      = 16,
  parameter int CH_ADDR   = 0,
  parameter int CSR_ADDR  = 2,
  parameter int OFS_ADDR  = 3,
  parameter int DATA_ADDR = 4,
  parameter int BUSY_BIT  = 8,
  parameter int WR_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_channel,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_data,
  input  logic [PL_W-1:0]   poll_limit,
  output logic              done,
  output logic              timeout,
  output logic [ADDR_W-1:0] bus_address,
  output logic              bus_read,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_writedata,
  input  logic [DATA_W-1:0] bus_readdata,
  input  logic              bus_waitrequest
);

  localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;

  phase_t phase_q, phase_d;
  logic   done_q, done_d, to_q, to_d;
  logic   accept, clear_cnt, acc_done, busy_rd, busy_hit, over;

  logic [CH_W-1:0]   ch_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign acc_done  = (bus_read || bus_write) && !bus_waitrequest;
  assign busy_rd   = |(bus_readdata & BUSY_MASK);
  assign busy_hit  = acc_done && is_poll(phase_q) && busy_rd;

  rcw_req_latch #(.CH_W(CH_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_ch(req_channel), .in_ofs(req_offset), .in_data(req_data),
    .ch_q(ch_q), .ofs_q(ofs_q), .data_q(data_q)
  );

  rcw_bus_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .OFS_W(OFS_W),
    .CH_ADDR(CH_ADDR), .CSR_ADDR(CSR_ADDR), .OFS_ADDR(OFS_ADDR),
    .DATA_ADDR(DATA_ADDR), .WR_BIT(WR_BIT)
  ) u_drive (
    .phase(phase_q), .ch(ch_q), .ofs(ofs_q), .data(data_q),
    .address(bus_address), .rd(bus_read), .wr(bus_write), .wdata(bus_writedata)
  );

  rcw_poll_guard #(.PL_W(PL_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .busy_hit(busy_hit),
    .limit(poll_limit), .over(over)
  );

  always_comb begin
    phase_d   = phase_q;
    done_d    = 1'b0;
    to_d      = 1'b0;
    clear_cnt = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d   = PH_PRE;
          clear_cnt = 1'b1;
        end
      end
      PH_PRE, PH_POST: begin
        if (acc_done) begin
          if (!busy_rd) begin
            phase_d = (phase_q == PH_PRE) ? PH_CHAN : PH_IDLE;
            done_d  = (phase_q == PH_POST);
          end else if (over) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
            to_d    = 1'b1;
          end
        end
      end
      PH_CHAN:   if (acc_done) phase_d = PH_OFS;
      PH_OFS:    if (acc_done) phase_d = PH_DATA;
      PH_DATA:   if (acc_done) phase_d = PH_LAUNCH;
      PH_LAUNCH: begin
        if (acc_done) begin
          phase_d   = PH_POST;
          clear_cnt = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      to_q    <= to_d;
    end
  end

  assign done    = done_q;
  assign timeout = to_q;

endmodule

// File: rtl/rcw_checker.sv
module rcw_checker #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              timeout,
  input logic [ADDR_W-1:0] bus_address,
  input logic              bus_read,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_writedata,
  input logic              bus_waitrequest
);

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_read || bus_write) && bus_waitrequest) |=>
      ($stable(bus_address) && $stable(bus_read) && $stable(bus_write) && $stable(bus_writedata)));

  assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_ready_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_read && !bus_write));

endmodule

bind reconfig_write_seq rcw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .timeout(timeout),
  .bus_address(bus_address), .bus_read(bus_read), .bus_write(bus_write),
  .bus_writedata(bus_writedata), .bus_waitrequest(bus_waitrequest)
);

// File: tb/sim_reconfig_write_seq.sv
`timescale 1ns/1ps
module sim_reconfig_write_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [9:0]  req_channel = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_data = '0;
  logic [15:0] poll_limit = '0;
  logic        done, timeout;
  logic [2:0]  bus_address;
  logic        bus_read, bus_write;
  logic [31:0] bus_writedata, bus_readdata;
  logic        bus_waitrequest;

  always #5 clk = ~clk;

  reconfig_write_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_channel(req_channel), .req_offset(req_offset), .req_data(req_data),
    .poll_limit(poll_limit), .done(done), .timeout(timeout),
    .bus_address(bus_address), .bus_read(bus_read), .bus_write(bus_write),
    .bus_writedata(bus_writedata), .bus_readdata(bus_readdata),
    .bus_waitrequest(bus_waitrequest)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural controller: W stall cycles per access, programmable busy lengths.
  logic        sl_load = 1'b0;
  int          sl_wait = 0, sl_p0 = 0, sl_p1 = 0;
  int          wcnt = 0, busy_left = 0, nwr = 0, pre_rd = 0, post_rd = 0;
  bit          launched = 0, hold_err = 0, both_err = 0, early_wr = 0, rd_bad = 0;
  logic [2:0]  wr_addr [8];
  logic [31:0] wr_data [8];
  logic        prev_pend = 1'b0, prev_rd = 1'b0, prev_wr = 1'b0;
  logic [2:0]  prev_addr = '0;
  logic [31:0] prev_wd = '0;

  assign bus_waitrequest = (bus_read || bus_write) && (wcnt < sl_wait);
  assign bus_readdata    = (busy_left > 0) ? 32'hABCD_0100 : 32'hABCD_FEFF;

  always @(posedge clk) begin
    if (sl_load) begin
      busy_left <= sl_p0; wcnt <= 0; nwr <= 0; pre_rd <= 0; post_rd <= 0;
      launched <= 0; hold_err <= 0; both_err <= 0; early_wr <= 0; rd_bad <= 0;
      prev_pend <= 1'b0;
    end else begin
      prev_pend <= (bus_read || bus_write) && bus_waitrequest;
      prev_addr <= bus_address; prev_rd <= bus_read; prev_wr <= bus_write;
      prev_wd <= bus_writedata;
      if (prev_pend && (bus_address != prev_addr || bus_read != prev_rd ||
                        bus_write != prev_wr || bus_writedata != prev_wd))
        hold_err <= 1;
      if (bus_read && bus_write) both_err <= 1;
      if (bus_read || bus_write) wcnt <= bus_waitrequest ? wcnt + 1 : 0;
      if (bus_read && !bus_waitrequest) begin
        if (bus_address != 3'd2) rd_bad <= 1;
        if (busy_left > 0) busy_left <= busy_left - 1;
        if (launched) post_rd <= post_rd + 1;
        else if (nwr == 0) pre_rd <= pre_rd + 1;
      end
      if (bus_write && !bus_waitrequest) begin
        if (nwr < 8) begin
          wr_addr[nwr] <= bus_address;
          wr_data[nwr] <= bus_writedata;
        end
        nwr <= nwr + 1;
        if (nwr == 0 && busy_left > 0) early_wr <= 1;
        if (bus_address == 3'd2 && bus_writedata[0]) begin
          busy_left <= sl_p1;
          launched  <= 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [9:0]  ch;
    logic [15:0] ofs;
    logic [31:0] dat;
    logic [3:0]  wt;
    logic [7:0]  p0;
    logic [7:0]  p1;
    logic [15:0] lim;
  } vec_t;

  // channel, offset, data, stall cycles, busy reads before, busy reads after, limit
  localparam vec_t VECS [6] = '{
    '{10'd5,    16'h0010, 32'h0000_A5A5, 4'd0, 8'd0, 8'd0, 16'd8},
    '{10'd1023, 16'hFFFF, 32'hFFFF_FFFF, 4'd2, 8'd3, 8'd5, 16'd8},
    '{10'd0,    16'h0007, 32'h1234_5678, 4'd1, 8'd0, 8'd4, 16'd4},
    '{10'd9,    16'h0022, 32'h0BAD_CAFE, 4'd1, 8'd3, 8'd0, 16'd2},
    '{10'd17,   16'h0101, 32'h7777_0001, 4'd0, 8'd1, 8'd9, 16'd3},
    '{10'd300,  16'h0abc, 32'h8000_0000, 4'd3, 8'd0, 8'd0, 16'd0}
  };

  task automatic run_vec(input vec_t v);
    bit pre_to, post_to;
    int pre_exp, post_exp, n_acc, lat_exp, acc_cyc, k;
    pre_to   = v.p0 > v.lim;
    post_to  = !pre_to && (v.p1 > v.lim);
    pre_exp  = pre_to ? int'(v.lim) + 1 : int'(v.p0) + 1;
    post_exp = pre_to ? 0 : (post_to ? int'(v.lim) + 1 : int'(v.p1) + 1);
    n_acc    = pre_exp + (pre_to ? 0 : 4) + post_exp;
    lat_exp  = n_acc * (int'(v.wt) + 1);
    @(negedge clk);
    sl_wait = v.wt; sl_p0 = v.p0; sl_p1 = v.p1; poll_limit = v.lim; sl_load = 1'b1;
    @(negedge clk);
    sl_load = 1'b0;
    req_valid = 1'b1; req_channel = v.ch; req_offset = v.ofs; req_data = v.dat;
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    acc_cyc = cyc + 1;
    @(negedge clk);
    // Scramble the request after acceptance: the writes must carry the latched values.
    req_valid = 1'b0; req_channel = ~v.ch; req_offset = ~v.ofs; req_data = ~v.dat;
    chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
    k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      chk(1'b0, "R7 watchdog, done never seen", k, lat_exp);
      return;
    end
    chk(cyc - acc_cyc == lat_exp, "R7 done latency", cyc - acc_cyc, lat_exp);
    chk(timeout == (pre_to || post_to), "R8 timeout flag", timeout, pre_to || post_to);
    chk(pre_rd == pre_exp, "R3 pre-poll reads", pre_rd, pre_exp);
    chk(post_rd == post_exp, "R5 post-poll reads", post_rd, post_exp);
    chk(nwr == (pre_to ? 0 : 4), "R4 R8 write count", nwr, pre_to ? 0 : 4);
    chk(!early_wr && !rd_bad, "R3 no write while busy, reads at CSR", early_wr, 0);
    chk(!hold_err, "R6 access held during stall", hold_err, 0);
    chk(!both_err, "R9 read and write exclusive", both_err, 0);
    if (!pre_to && nwr == 4) begin
      chk(wr_addr[0] == 3'd0 && wr_data[0] == 32'(v.ch), "R4 R2 channel write", wr_data[0], v.ch);
      chk(wr_addr[1] == 3'd3 && wr_data[1] == 32'(v.ofs), "R4 R2 offset write", wr_data[1], v.ofs);
      chk(wr_addr[2] == 3'd4 && wr_data[2] == v.dat, "R4 R2 data write", wr_data[2], v.dat);
      chk(wr_addr[3] == 3'd2 && wr_data[3] == 32'd1, "R4 launch write", wr_data[3], 1);
    end
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    chk(!bus_read && !bus_write && req_ready, "R8 idle after finish", {bus_read, bus_write}, 0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    chk(1'b0, "R7 global watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_read && !bus_write && !done && !timeout,
        "R1 reset state", {req_ready, bus_read, bus_write, done, timeout}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_read && !bus_write && req_ready, "R2 no access without request",
        {bus_read, bus_write}, 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // Reset in the middle of a long pre-poll.
    @(negedge clk);
    sl_wait = 0; sl_p0 = 50; sl_p1 = 0; poll_limit = 16'd100; sl_load = 1'b1;
    @(negedge clk);
    sl_load = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(bus_read == 1'b1, "R3 polling in progress", bus_read, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !bus_read && !bus_write && !done && !timeout,
        "R1 reset mid-operation", {req_ready, bus_read, bus_write}, 3'b100);
    rst_n = 1'b1;
    run_vec(VECS[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule